// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Status Bank

This block collects the interrupt sources of one serial port and folds them into a single interrupt line. Each of fourteen source positions has a mask bit and a sticky status bit. Software can change the mask only through two write-only registers. One of them sets mask bits and the other clears them. A ones-bit in either register acts on that position, and a zero bit leaves that position alone.

An event pulse on a source reaches the status register only while its mask bit is set. A status bit then stays set until software writes a one to it. A separate raw view shows the live level conditions of the sources whatever the mask holds. The four modem-line change indications are merged into one shared source position.

Register access uses a plain 32-bit bus with an address, a write strobe, write data and combinational read data. The serial datapath and the logic that produces the events are outside this block.

Top module: `uart_irq_bank`

## Requirements
- R1: After reset the mask and status registers read zero and `irq` is low.
- R2: A write to the mask-set register (offset 0x00) sets every mask bit whose write-data bit is one and leaves the other mask bits unchanged. The mask reads back at offset 0x08.
- R3: A write to the mask-clear register (offset 0x04) clears every mask bit whose write-data bit is one and leaves the other mask bits unchanged.
- R4: Reads of offsets 0x00 and 0x04 return zero. A write to the mask offset 0x08 has no effect on the mask.
- R5: Only bits 13:0 exist. Write-data bits 31:14 are ignored, and bits 31:14 of every read are zero.
- R6: A pulse on `src_pulse[i]` sets status bit i (read at offset 0x0C) on the next clock edge only when mask bit i is set. When mask bit i is clear the pulse has no effect on the status.
- R7: Writing a one to bit i of the status offset 0x0C clears status bit i. Zero bits leave their status bits unchanged.
- R8: When an unmasked event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: The raw view at offset 0x10 returns `src_level`, with bit 9 also ORed with any asserted `modem_delta` line, regardless of the mask.
- R10: Any of the four `modem_delta` lines (bit 0 CTS change, bit 1 DSR change, bit 2 ring trailing edge, bit 3 DCD change) acts as an event on source 9, the modem status change source.
- R11: `irq` is high exactly while at least one status bit is set, and it stays high until every set bit has been cleared.
- R12: Writes to the status offset can never set a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| src_pulse | input | 14 | One-cycle event pulses per source (bit 0 RX trigger, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing, 7 parity, 8 RX timeout, 9 modem change, 10 TX trigger, 11 TX nearly full, 12 TX overflow, 13 break) |
| src_level | input | 14 | Live level conditions shown in the raw view |
| modem_delta | input | 4 | Modem-line change indications |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can meet on the same status bit in one cycle: the arrival of an unmasked event and a clear-by-write from software. The bench provokes this by raising a source pulse in the very cycle that carries a write of a one to the same status position. After the edge it reads the status register back. The bit must still be set and `irq` must remain high. A second case checks that a clear of one bit still takes effect while a different bit is being set in the same cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int SRC_W     = 14;
    localparam int MODEM_W   = 4;
    localparam int MODEM_BIT = 9;
    localparam int OFS_W     = 5;

    typedef logic [SRC_W-1:0] src_vec_t;

    typedef enum logic [OFS_W-1:0] {
        OFS_MSET = 5'h00,
        OFS_MCLR = 5'h04,
        OFS_MASK = 5'h08,
        OFS_STAT = 5'h0C,
        OFS_RAW  = 5'h10
    } uirq_ofs_e;

    typedef struct packed {
        logic     set_mask;
        logic     clr_mask;
        logic     clr_stat;
        src_vec_t bits;
    } uirq_cmd_t;

    function automatic src_vec_t fold_modem(src_vec_t v, logic [MODEM_W-1:0] d);
        src_vec_t r;
        r = v;
        r[MODEM_BIT] = v[MODEM_BIT] | (|d);
        return r;
    endfunction

endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output uirq_cmd_t         cmd
);
    logic [OFS_W-1:0] ofs;
    assign ofs = OFS_W'(addr);

    always_comb begin
        cmd          = '0;
        cmd.bits     = wdata[SRC_W-1:0];
        cmd.set_mask = wr && (ofs == OFS_MSET);
        cmd.clr_mask = wr && (ofs == OFS_MCLR);
        cmd.clr_stat = wr && (ofs == OFS_STAT);
    end
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
    import uirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  uirq_cmd_t cmd,
    output src_vec_t  mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (cmd.set_mask) begin
            mask_q <= mask_q | cmd.bits;
        end else if (cmd.clr_mask) begin
            mask_q <= mask_q & ~cmd.bits;
        end
    end
endmodule

// File: rtl/uirq_status_reg.sv
module uirq_status_reg
    import uirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  uirq_cmd_t cmd,
    input  src_vec_t  events,
    input  src_vec_t  mask_q,
    output src_vec_t  stat_q
);
    src_vec_t clr_bits;
    src_vec_t hit_bits;

    assign clr_bits = cmd.clr_stat ? cmd.bits : '0;
    assign hit_bits = events & mask_q;

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= 1'b0;
            end else if (hit_bits[i]) begin
                stat_q[i] <= 1'b1;
            end else if (clr_bits[i]) begin
                stat_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uirq_read_mux.sv
module uirq_read_mux
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  src_vec_t          mask_q,
    input  src_vec_t          stat_q,
    input  src_vec_t          raw_v,
    output logic [DATA_W-1:0] rdata
);
    logic [OFS_W-1:0] ofs;
    assign ofs = OFS_W'(addr);

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_MASK: rdata[SRC_W-1:0] = mask_q;
            OFS_STAT: rdata[SRC_W-1:0] = stat_q;
            OFS_RAW:  rdata[SRC_W-1:0] = raw_v;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_W-1:0]  src_pulse,
    input  logic [SRC_W-1:0]  src_level,
    input  logic [MODEM_W-1:0] modem_delta,
    output logic              irq
);
    uirq_cmd_t cmd;
    src_vec_t  mask_q;
    src_vec_t  stat_q;
    src_vec_t  events;
    src_vec_t  raw_v;

    assign events = fold_modem(src_pulse, modem_delta);
    assign raw_v  = fold_modem(src_level, modem_delta);

    uirq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .wdata(bus_wdata),
        .cmd  (cmd)
    );

    uirq_mask_reg u_mask (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .mask_q(mask_q)
    );

    uirq_status_reg u_stat (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .events(events),
        .mask_q(mask_q),
        .stat_q(stat_q)
    );

    uirq_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .addr  (bus_addr),
        .mask_q(mask_q),
        .stat_q(stat_q),
        .raw_v (raw_v),
        .rdata (bus_rdata)
    );

    assign irq = |stat_q;
endmodule

// File: rtl/uart_irq_bank_chk.sv
module uart_irq_bank_chk
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [SRC_W-1:0]  src_pulse,
    input logic [MODEM_W-1:0] modem_delta,
    input logic [SRC_W-1:0]  mask_q,
    input logic [SRC_W-1:0]  stat_q,
    input logic              irq
);
    logic [SRC_W-1:0] wbits;
    logic             w_set, w_clr, w_stat;
    assign wbits  = bus_wdata[SRC_W-1:0];
    assign w_set  = bus_wr && (OFS_W'(bus_addr) == OFS_MSET);
    assign w_clr  = bus_wr && (OFS_W'(bus_addr) == OFS_MCLR);
    assign w_stat = bus_wr && (OFS_W'(bus_addr) == OFS_STAT);

    // R1: registers leave reset at zero
    p_reset_zero_r1: assert property (@(posedge clk)
        $fell(rst) |-> (mask_q == '0 && stat_q == '0 && !irq));

    // R2: set register turns selected mask bits on, keeps others
    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        w_set |=> (mask_q == ($past(mask_q) | $past(wbits))));

    // R3: clear register turns selected mask bits off, keeps others
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
        w_clr |=> (mask_q == ($past(mask_q) & ~$past(wbits))));

    // R4: mask changes only through the set and clear registers
    p_mask_ro_r4: assert property (@(posedge clk) disable iff (rst)
        (!w_set && !w_clr) |=> $stable(mask_q));

    // R6: a status bit can only rise where the mask was set
    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));

    // R8: an unmasked event always leaves its status bit set
    p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ((fold_modem(src_pulse, modem_delta) & mask_q) != '0) |=>
        ((stat_q & $past(fold_modem(src_pulse, modem_delta) & mask_q))
          == $past(fold_modem(src_pulse, modem_delta) & mask_q)));

    // R11: interrupt stays high when no clearing write happens
    p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq && !w_stat) |=> irq);

    // R12: without events, status never gains bits
    p_no_set_r12: assert property (@(posedge clk) disable iff (rst)
        ((src_pulse == '0) && (modem_delta == '0)) |=> ((stat_q & ~$past(stat_q)) == '0));
endmodule

bind uart_irq_bank uart_irq_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .src_pulse  (src_pulse),
    .modem_delta(modem_delta),
    .mask_q     (mask_q),
    .stat_q     (stat_q),
    .irq        (irq)
);

// File: tb/uart_irq_bank_bench.sv
`timescale 1ns/1ps
module uart_irq_bank_bench;
    localparam logic [4:0] A_MSET = 5'h00;
    localparam logic [4:0] A_MCLR = 5'h04;
    localparam logic [4:0] A_MASK = 5'h08;
    localparam logic [4:0] A_STAT = 5'h0C;
    localparam logic [4:0] A_RAW  = 5'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [13:0] src_pulse = '0;
    logic [13:0] src_level = '0;
    logic [3:0]  modem_delta = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uart_irq_bank u_uart_irq_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
        .src_level(src_level), .modem_delta(modem_delta), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(logic [13:0] ev, logic [3:0] md);
        @(negedge clk);
        src_pulse = ev; modem_delta = md;
        @(negedge clk);
        src_pulse = '0; modem_delta = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_MASK, v); check("R1 mask", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_mask_set;
        logic [31:0] v;
        wr(A_MSET, 32'h0005);
        rd(A_MASK, v); check("R2 first set", v, 32'h0005);
        wr(A_MSET, 32'h0100);
        rd(A_MASK, v); check("R2 accumulate", v, 32'h0105);
        wr(A_MSET, 32'hFFFF_C000);
        rd(A_MASK, v); check("R5 upper bits ignored", v, 32'h0105);
    endtask

    task automatic t_mask_clr;
        logic [31:0] v;
        wr(A_MCLR, 32'h0004);
        rd(A_MASK, v); check("R3 clear one", v, 32'h0101);
        rd(A_MSET, v); check("R4 set reg reads zero", v, 0);
        rd(A_MCLR, v); check("R4 clear reg reads zero", v, 0);
        wr(A_MASK, 32'h3FFF);
        rd(A_MASK, v); check("R4 mask not writable", v, 32'h0101);
    endtask

    task automatic t_gate;
        logic [31:0] v;
        pulse(14'h0002, 4'h0);
        rd(A_STAT, v); check("R6 masked event blocked", v, 0);
        check("R11 irq low", {31'b0, irq}, 0);
        pulse(14'h0001, 4'h0);
        rd(A_STAT, v); check("R6 unmasked event", v, 32'h0001);
        check("R11 irq high", {31'b0, irq}, 1);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(A_STAT, 32'h0002);
        rd(A_STAT, v); check("R12 write cannot set", v, 32'h0001);
        check("R11 irq held", {31'b0, irq}, 1);
        wr(A_STAT, 32'h0001);
        rd(A_STAT, v); check("R7 write-one clears", v, 0);
        check("R11 irq drops", {31'b0, irq}, 0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(A_MSET, 32'h0020);
        pulse(14'h0020, 4'h0);
        pulse(14'h0001, 4'h0);
        rd(A_STAT, v); check("R6 two bits set", v, 32'h0021);
        @(negedge clk);
        bus_addr = A_STAT; bus_wr = 1'b1; bus_wdata = 32'h0021; src_pulse = 14'h0020;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; src_pulse = '0;
        rd(A_STAT, v); check("R8 event beats clear", v, 32'h0020);
        check("R8 irq stays", {31'b0, irq}, 1);
        wr(A_STAT, 32'h0020);
        rd(A_STAT, v); check("R7 cleared afterwards", v, 0);
    endtask

    task automatic t_modem;
        logic [31:0] v;
        pulse(14'h0000, 4'h4);
        rd(A_STAT, v); check("R10 modem masked", v, 0);
        wr(A_MSET, 32'h0200);
        for (int k = 0; k < 4; k++) begin
            pulse(14'h0000, 4'(1 << k));
            rd(A_STAT, v); check($sformatf("R10 modem line %0d", k), v, 32'h0200);
            wr(A_STAT, 32'h0200);
        end
        rd(A_STAT, v); check("R10 cleared", v, 0);
    endtask

    task automatic t_raw;
        logic [31:0] v;
        wr(A_MCLR, 32'h3FFF);
        @(negedge clk);
        src_level = 14'h2808;
        rd(A_RAW, v); check("R9 raw ignores mask", v, 32'h2808);
        @(negedge clk);
        modem_delta = 4'h8;
        rd(A_RAW, v); check("R9 raw modem fold", v, 32'h2A08);
        @(negedge clk);
        modem_delta = 4'h0; src_level = '0;
        rd(A_STAT, v); check("R6 no status while masked", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mask_set();
        t_mask_clr();
        t_gate();
        t_clear();
        t_collide();
        t_modem();
        t_raw();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule